// File: doc/BRIEF.md
# Key Event Queue with Host Interrupt

This block turns activity on a scanned switch matrix into bytes that a host can read, and raises an interrupt when something is waiting. There are three capture modes. In keyboard mode, a debounced closure pulse (`key_hit`) stores one byte for the pressed key. The byte holds the scan row, the return column and the levels seen on the shift and control lines. In sensor mode, any change on the return lines stores the new return byte and flags the change. In strobed mode, the return lines act as an 8-bit parallel port that is loaded on each rising edge of the control line.

Entries go into an 8-deep first-in first-out queue. The host reads the oldest entry combinationally on `rd_data` and removes it with a one-cycle `rd_en` pulse. An interrupt controller built as a three-state machine drives `irq`:
- `IRQ_IDLE` moves to `IRQ_ASSERT` when a cause is present and no read is in progress.
- `IRQ_ASSERT` moves to `IRQ_HOLDOFF` on a read. It returns to `IRQ_IDLE` if the cause disappears.
- `IRQ_HOLDOFF` always lasts exactly one clock. It then goes back to `IRQ_ASSERT` if the cause is still present, or to `IRQ_IDLE` if it is not.

In keyboard and strobed modes the cause is a non-empty queue. In sensor mode the cause is a pending-change flag, which a change sets and a read clears.

Top module: `keyscan_fifo_irq`

## Requirements
- R1: After reset `irq` and `overrun` are 0, the queue is empty, and `rd_data` reads 0 while the queue is empty.
- R2: The mode encoding is 00 keyboard, 01 sensor, 10 strobed, and 11 behaves as keyboard. In keyboard mode a `key_hit` cycle stores `{ctrl_n, shift_n, scan_row[2:0], col[2:0]}`, with ctrl in bit 7 and the column in bits 2:0. The column `col` is the index of the lowest return line that reads 0. A `key_hit` while all return lines read 1 stores nothing.
- R3: The queue holds up to 8 entries and returns them in the order they were stored.
- R4: A store into a full queue that is not read in the same cycle is dropped. It sets `overrun`, which stays 1 until reset.
- R5: In keyboard and strobed modes `irq` goes to 1 on the second clock edge after the queue becomes non-empty.
- R6: A read while `irq` is 1 drives `irq` to 0 for exactly one clock. `irq` then returns to 1 if entries remain and stays 0 if the queue is empty.
- R7: In sensor mode, a return-line value that differs from the previous clock's value stores the new byte and raises `irq`. After the read, `irq` stays 0 until the return lines change again.
- R8: In strobed mode, a rising edge of `ctrl_n` stores `ret_n`. A falling edge stores nothing, and `key_hit` stores nothing.
- R9: A store and a read in the same cycle on a full queue both take effect, and `overrun` stays 0. A read of an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Capture mode select |
| scan_row | input | 3 | Row currently being scanned |
| ret_n | input | 8 | Return lines, active low |
| shift_n | input | 1 | Shift line level |
| ctrl_n | input | 1 | Control line level; strobe in strobed mode |
| key_hit | input | 1 | Debounced closure pulse |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Oldest entry, or 0 when the queue is empty |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky lost-entry flag |

## Verification
Two functions can fall in the same cycle:
- a capture store together with a host pop;
- a host pop together with the interrupt state machine's re-arm decision.

The first is provoked by filling the queue to 8 entries and then pulsing `key_hit` and `rd_en` on the same clock. It is judged by `overrun` staying 0 and by draining all 8 entries in order, with the new one last. The second is provoked by reading with two entries queued. It is judged by `irq` being 0 in the cycle after the read and 1 in the cycle after that.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
    typedef enum logic [1:0] {
        MODE_KEYS   = 2'b00,
        MODE_SENSE  = 2'b01,
        MODE_STROBE = 2'b10,
        MODE_RSVD   = 2'b11
    } cap_mode_e;

    typedef enum logic [1:0] {
        IRQ_IDLE    = 2'b00,
        IRQ_ASSERT  = 2'b01,
        IRQ_HOLDOFF = 2'b10
    } irq_state_e;
endpackage

// File: rtl/keyscan_capture.sv
module keyscan_capture
    import keyscan_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int RET_W = 8,
    localparam int COL_W  = $clog2(RET_W),
    localparam int DATA_W = 2 + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [ROW_W-1:0]  scan_row,
    input  logic [RET_W-1:0]  ret_n,
    input  logic              shift_n,
    input  logic              ctrl_n,
    input  logic              key_hit,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              sense_change
);
    logic [RET_W-1:0] ret_prev;
    logic             ctrl_prev;
    logic [COL_W-1:0] col;
    logic             any_low;
    logic             strobe_rise;
    cap_mode_e        cur_mode;

    assign cur_mode = cap_mode_e'(mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_prev  <= '1;
            ctrl_prev <= 1'b1;
        end else begin
            ret_prev  <= ret_n;
            ctrl_prev <= ctrl_n;
        end
    end

    always_comb begin
        col     = '0;
        any_low = 1'b0;
        for (int i = RET_W - 1; i >= 0; i--) begin
            if (!ret_n[i]) begin
                col     = COL_W'(i);
                any_low = 1'b1;
            end
        end
    end

    assign strobe_rise = ctrl_n && !ctrl_prev;

    always_comb begin
        push         = 1'b0;
        push_data    = '0;
        sense_change = 1'b0;
        unique case (cur_mode)
            MODE_SENSE: begin
                sense_change = (ret_n != ret_prev);
                push         = sense_change;
                push_data    = DATA_W'(ret_n);
            end
            MODE_STROBE: begin
                push      = strobe_rise;
                push_data = DATA_W'(ret_n);
            end
            MODE_KEYS, MODE_RSVD: begin
                push      = key_hit && any_low;
                push_data = {ctrl_n, shift_n, scan_row, col};
            end
            default: ;
        endcase
    end

    // R8: a store in strobed mode only follows a low-to-high strobe step
    a_r8_strobe_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_STROBE && push) |-> (ctrl_n && !ctrl_prev));
endmodule

// File: rtl/keyscan_queue.sv
module keyscan_queue #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              overrun
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic              full, pop, wr;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign pop   = rd_en && !empty;
    assign wr    = push && (!full || pop);
    assign head  = empty ? '0 : mem[rptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr)  wptr <= step(wptr);
            if (pop) rptr <= step(rptr);
            if (wr && !pop)      count <= count + 1'b1;
            else if (pop && !wr) count <= count - 1'b1;
            if (push && !wr)     overrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) mem[wptr] <= push_data;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rd_en && !full) |=> (count == $past(count) + 1'b1));
    a_r4_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !rd_en) |=> (overrun && count == $past(count)));
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    a_r9_both_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rd_en && full && !overrun) |=> (!overrun && full));
endmodule

// File: rtl/keyscan_irq_ctrl.sv
module keyscan_irq_ctrl
    import keyscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       q_empty,
    input  logic       sense_change,
    input  logic       rd_en,
    output logic       irq
);
    irq_state_e state, state_nx;
    logic       pend;
    logic       cause;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pend <= 1'b0;
        else if (sense_change)   pend <= 1'b1;
        else if (rd_en)          pend <= 1'b0;
    end

    assign cause = (cap_mode_e'(mode) == MODE_SENSE) ? pend : !q_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE:    if (cause && !rd_en) state_nx = IRQ_ASSERT;
            IRQ_ASSERT:  if (rd_en)           state_nx = IRQ_HOLDOFF;
                         else if (!cause)     state_nx = IRQ_IDLE;
            IRQ_HOLDOFF: state_nx = cause ? IRQ_ASSERT : IRQ_IDLE;
            default:     state_nx = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state == IRQ_ASSERT);
    end

    a_r6_drop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rd_en) |=> !irq);
    a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode == $past(mode)) |-> cause);
    a_r7_sense_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        sense_change |=> pend);
endmodule

// File: rtl/keyscan_fifo_irq.sv
module keyscan_fifo_irq
    import keyscan_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int RET_W = 8,
    parameter int DEPTH = 8,
    localparam int DATA_W = 2 + ROW_W + $clog2(RET_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [ROW_W-1:0]  scan_row,
    input  logic [RET_W-1:0]  ret_n,
    input  logic              shift_n,
    input  logic              ctrl_n,
    input  logic              key_hit,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              overrun
);
    logic              push, sense_change, q_empty;
    logic [DATA_W-1:0] push_data;

    keyscan_capture #(.ROW_W(ROW_W), .RET_W(RET_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .mode(mode), .scan_row(scan_row),
        .ret_n(ret_n), .shift_n(shift_n), .ctrl_n(ctrl_n),
        .key_hit(key_hit), .push(push), .push_data(push_data),
        .sense_change(sense_change)
    );

    keyscan_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .rd_en(rd_en), .head(rd_data), .empty(q_empty), .overrun(overrun)
    );

    keyscan_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .q_empty(q_empty),
        .sense_change(sense_change), .rd_en(rd_en), .irq(irq)
    );

    a_r1_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (rd_data == '0));
endmodule

// File: tb/keyscan_fifo_irq_bench.sv
module keyscan_fifo_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {row[2:0], ret[7:0], shift, ctrl, expected[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {3'd0, 8'hFE, 1'b1, 1'b1, 8'hC0},
        {3'd5, 8'h7F, 1'b0, 1'b1, 8'hAF},
        {3'd3, 8'hF3, 1'b1, 1'b0, 8'h5A},
        {3'd7, 8'h00, 1'b0, 1'b0, 8'h38},
        {3'd2, 8'hDF, 1'b1, 1'b1, 8'hD5},
        {3'd6, 8'hEF, 1'b0, 1'b0, 8'h34}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [2:0] scan_row = '0;
    logic [7:0] ret_n = 8'hFF;
    logic       shift_n = 1'b1, ctrl_n = 1'b1, key_hit = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq, overrun;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyscan_fifo_irq u_keyscan_fifo_irq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .scan_row(scan_row),
        .ret_n(ret_n), .shift_n(shift_n), .ctrl_n(ctrl_n),
        .key_hit(key_hit), .rd_en(rd_en), .rd_data(rd_data),
        .irq(irq), .overrun(overrun)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode = m; ret_n = 8'hFF; ctrl_n = 1'b1; shift_n = 1'b1;
        key_hit = 1'b0; rd_en = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic key(input logic [2:0] r, input logic [7:0] rt, input logic s, input logic c);
        scan_row = r; ret_n = rt; shift_n = s; ctrl_n = c; key_hit = 1'b1;
        @(negedge clk);
        key_hit = 1'b0; ret_n = 8'hFF; shift_n = 1'b1; ctrl_n = 1'b1;
    endtask

    task automatic pop(input string req, input logic [7:0] exp);
        check(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 overrun", {7'd0, overrun}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);

        // R2 packing via vector table
        foreach (VEC[i]) begin
            key(VEC[i][20:18], VEC[i][17:10], VEC[i][9], VEC[i][8]);
            @(negedge clk);
            pop("R2 entry", VEC[i][7:0]);
            @(negedge clk);
        end

        // R2 all-high return: nothing stored
        key(3'd1, 8'hFF, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 no-column empty", rd_data, 8'h00);
        check("R2 no-column irq", {7'd0, irq}, 8'h00);
        // R2 reserved mode acts as keyboard
        mode = 2'b11;
        key(3'd4, 8'hFD, 1'b1, 1'b1);
        check("R2 rsvd mode", rd_data, 8'hE1);
        @(negedge clk);
        pop("R2 rsvd pop", 8'hE1);
        mode = 2'b00;

        // R5/R6 irq timing with two entries
        do_reset(2'b00);
        key(3'd1, 8'hFE, 1'b1, 1'b1);
        check("R5 irq not yet", {7'd0, irq}, 8'h00);
        key(3'd2, 8'hFE, 1'b1, 1'b1);
        check("R5 irq up", {7'd0, irq}, 8'h01);
        pop("R3 first", 8'hC8);
        check("R6 irq dropped", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R6 irq rearmed", {7'd0, irq}, 8'h01);
        pop("R3 second", 8'hD0);
        check("R6 low after last", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R6 stays low", {7'd0, irq}, 8'h00);

        // R3/R4 fill, overflow, order
        do_reset(2'b00);
        for (int k = 0; k < 9; k++) key(3'(k), 8'hFE, 1'b1, 1'b1);
        check("R4 overrun set", {7'd0, overrun}, 8'h01);
        for (int k = 0; k < 8; k++) begin
            pop("R3 order", {2'b11, 3'(k), 3'b000});
            @(negedge clk);
        end
        check("R4 ninth dropped", rd_data, 8'h00);
        check("R4 overrun sticky", {7'd0, overrun}, 8'h01);

        // R9 simultaneous store and read on full queue
        do_reset(2'b00);
        for (int k = 0; k < 8; k++) key(3'(k), 8'hFE, 1'b1, 1'b1);
        check("R9 head before", rd_data, 8'hC0);
        rd_en = 1'b1;
        key(3'd7, 8'h7F, 1'b1, 1'b1);
        rd_en = 1'b0;
        check("R9 overrun clear", {7'd0, overrun}, 8'h00);
        for (int k = 1; k < 8; k++) pop("R9 drain", {2'b11, 3'(k), 3'b000});
        pop("R9 new last", 8'hFF);
        check("R9 empty", rd_data, 8'h00);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        check("R9 empty read ignored", {7'd0, overrun}, 8'h00);
        key(3'd3, 8'hFB, 1'b1, 1'b1);
        check("R9 after empty read", rd_data, 8'hDA);

        // R7 sensor mode
        do_reset(2'b01);
        ret_n = 8'hF7;
        @(negedge clk);
        check("R7 irq pending", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R7 irq up", {7'd0, irq}, 8'h01);
        pop("R7 byte", 8'hF7);
        repeat (3) @(negedge clk);
        check("R7 quiet", {7'd0, irq}, 8'h00);
        check("R7 no extra entry", rd_data, 8'h00);
        key(3'd2, 8'hF7, 1'b0, 1'b0);
        // key() restored ret_n to FF: that is a change
        @(negedge clk);
        check("R7 key_hit ignored", rd_data, 8'hFF);
        @(negedge clk);
        check("R7 irq again", {7'd0, irq}, 8'h01);

        // R8 strobed mode
        do_reset(2'b10);
        ret_n = 8'h3C; ctrl_n = 1'b0;
        @(negedge clk);
        check("R8 falling ignored", rd_data, 8'h00);
        ctrl_n = 1'b1;
        @(negedge clk);
        ret_n = 8'hFF;
        check("R8 rising stored", rd_data, 8'h3C);
        @(negedge clk);
        check("R5 strobe irq", {7'd0, irq}, 8'h01);
        pop("R8 pop", 8'h3C);
        key(3'd1, 8'hFE, 1'b1, 1'b1);
        check("R8 key_hit ignored", rd_data, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule